// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O port controlled through a small synchronous register port. Each pin can be driven from an output data register under the control of an output-enable bit, and each pin's synchronized input value can be read back. Every writable register can be written three ways: a whole-word write, an atomic bit-set alias and an atomic bit-clear alias. With the aliases, software changes individual pins without a read-modify-write sequence.

Each pin also feeds an event detector. A two-bit trigger code per pin selects the falling edge, low level, rising edge or high level. A per-pin detect enable gates whether events are latched into a sticky status bit. A separate per-pin interrupt enable gates only whether a latched status bit reaches the single port interrupt line. Software acknowledges events by writing ones to the status clear alias.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_o`, `pin_oe_o` and `irq_o` are low, and `rdata_o` is zero.
- R2: Register base addresses are 0x00 output data, 0x10 input data, 0x20 output enable, 0x30 detect enable, 0x40 interrupt enable, 0x50 level select, 0x60 polarity, 0x70 status. A write at base+0x0 loads the word, a write at base+0x4 sets the bits written as 1, and a write at base+0x8 clears the bits written as 1. Address bit 7 must be 0. A read at the base returns the register on `rdata_o` one cycle later.
- R3: The status register changes by software only through its clear alias (0x78). Whole-word and set-alias writes to status, and any write to the input data register, have no effect.
- R4: `pin_o` equals the output data register and `pin_oe_o` equals the output enable register, bit for bit. A 1 in output enable means the pin is driven.
- R5: The input data register shows the pin inputs through a two-flop synchronizer. A read issued one cycle after a pin change still returns the old value, and the next read returns the new one.
- R6: The trigger code of pin i is {polarity[i], level[i]}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. A matching event sets status[i].
- R7: An event on pin i reaches status[i] only while detect enable bit i is 1.
- R8: `irq_o` is high exactly when some bit is set in both status and interrupt enable. Interrupt enable has no effect on status.
- R9: In level mode the status bit is set on every cycle the active level is present, so it is set again at once after a clear while the level persists.
- R10: When an event and a status clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pin_i | input | 32 | Pin input values, asynchronous |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The bench drives a long sequence of pin vectors. Every pin carries one of the four trigger codes, so all modes see rising, falling and static inputs together. A swapped polarity or level decode shows up as status bits on the wrong pins. A detector that confuses edge and level either misses a held level after a clear or keeps re-latching an edge. The same-cycle clear-versus-event case is driven at the exact cycle where an edge lands in status. A design that lets the clear win loses the event. The sweep repeats with partial detect and interrupt enables, which exposes an enable that gates the wrong stage. Reading input data one cycle after a change catches a synchronizer of the wrong depth.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int NREG     = 8;
  localparam int RI_OUT   = 0;
  localparam int RI_IN    = 1;
  localparam int RI_OE    = 2;
  localparam int RI_DET   = 3;
  localparam int RI_IEN   = 4;
  localparam int RI_LVL   = 5;
  localparam int RI_POL   = 6;
  localparam int RI_STAT  = 7;

  typedef enum logic [1:0] {
    AL_WORD = 2'd0,
    AL_SET  = 2'd1,
    AL_CLR  = 2'd2,
    AL_RSV  = 2'd3
  } alias_e;

  // trigger code {pol, lvl}
  function automatic logic trig_hit(logic pol, logic lvl, logic cur, logic prev);
    case ({pol, lvl})
      2'b00:   return !cur && prev;
      2'b01:   return !cur;
      2'b10:   return cur && !prev;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_rw_reg.sv
`timescale 1ns/1ps
module gpio_rw_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wr_i)  q_o <= wdata_i;
    else if (set_i) q_o <= q_o | wdata_i;
    else if (clr_i) q_o <= q_o & ~wdata_i;
  end
endmodule

// File: rtl/gpio_detect.sv
`timescale 1ns/1ps
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= din_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign ev_o[i] = en_i[i] && trig_hit(pol_i[i], lvl_i[i], din_i[i], prev_q[i]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W           = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  pin_i,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe_o,
  output logic          irq_o
);
  localparam int IDX_LSB = 4;
  localparam int IDX_W   = $clog2(NREG);
  localparam int TOP_LSB = IDX_LSB + IDX_W;

  logic              acc;
  logic [IDX_W-1:0]  idx;
  alias_e            al;
  logic [NREG-1:0]   wsel;
  logic [W-1:0]      regs [NREG];
  logic [W-1:0]      din;
  logic [W-1:0]      stat_q;
  logic [W-1:0]      ev;
  logic [W-1:0]      det_en_q;
  logic [W-1:0]      ien_q;

  assign acc  = req_i && (addr_i[AW-1:TOP_LSB] == '0);
  assign idx  = addr_i[TOP_LSB-1:IDX_LSB];
  assign al   = alias_e'(addr_i[3:2]);
  assign wsel = (acc && we_i) ? (NREG'(1) << idx) : '0;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (din)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == RI_IN) begin : g_in
      assign regs[i] = din;
    end else if (i == RI_STAT) begin : g_stat
      assign regs[i] = stat_q;
    end else begin : g_rw
      gpio_rw_reg #(.W(W)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wsel[i] && al == AL_WORD),
        .set_i  (wsel[i] && al == AL_SET),
        .clr_i  (wsel[i] && al == AL_CLR),
        .wdata_i(wdata_i),
        .q_o    (regs[i])
      );
    end
  end

  assign det_en_q = regs[RI_DET];
  assign ien_q    = regs[RI_IEN];

  gpio_detect #(.W(W)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (din),
    .lvl_i (regs[RI_LVL]),
    .pol_i (regs[RI_POL]),
    .en_i  (det_en_q),
    .ev_o  (ev)
  );

  // new event overrides a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (wsel[RI_STAT] && al == AL_CLR) stat_q <= (stat_q & ~wdata_i) | ev;
    else stat_q <= stat_q | ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_o <= '0;
    else if (req_i && !we_i)     rdata_o <= acc ? regs[idx] : '0;
  end

  assign pin_o    = regs[RI_OUT];
  assign pin_oe_o = regs[RI_OE];
  assign irq_o    = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  pin_o,
  input logic [W-1:0]  pin_oe_o,
  input logic          irq_o,
  input logic [W-1:0]  stat_q,
  input logic [W-1:0]  det_en_q,
  input logic [W-1:0]  ien_q,
  input logic [W-1:0]  ev
);
  logic stat_clr_hit;
  assign stat_clr_hit = req_i && we_i && (addr_i == AW'(8'h78));

  // R3: without a clear-alias write, status bits never drop
  a_r3_stat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr_hit |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R4: pin outputs only move on a register write
  a_r4_pins_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  // R7: a newly set status bit had its detect enable on
  a_r7_det_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(det_en_q)) == '0));

  // R8: interrupt needs an enabled, pending bit
  a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat_q & ien_q) != '0));

  // R10: every event lands in status, clear or not
  a_r10_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .stat_q  (stat_q),
  .det_en_q(det_en_q),
  .ien_q   (ien_q),
  .ev      (ev)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_OUT = 8'h00, A_IN = 8'h10, A_OE = 8'h20, A_DET = 8'h30,
                         A_IEN = 8'h40, A_LVL = 8'h50, A_POL = 8'h60, A_STAT = 8'h70;
  localparam logic [7:0] SETO = 8'h4, CLRO = 8'h8;
  localparam logic [31:0] LVL_CFG = 32'hAAAA_AAAA;  // pin i: lvl = i[0]
  localparam logic [31:0] POL_CFG = 32'hCCCC_CCCC;  // pin i: pol = i[1]

  always #5 clk = ~clk;

  gpio_irq_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    req = 1'b0;
    d = rdata;
  endtask

  // expected status after clearing with vector u held, then applying v
  function automatic logic [31:0] exp_stat(logic [31:0] u, logic [31:0] v, logic [31:0] den);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      logic pol = POL_CFG[i];
      logic lvl = LVL_CFG[i];
      if (lvl) r[i] = pol ? (u[i] | v[i]) : (!u[i] | !v[i]);
      else     r[i] = pol ? (!u[i] & v[i]) : (u[i] & !v[i]);
    end
    return r & den;
  endfunction

  function automatic logic [31:0] lfsr(logic [31:0] x);
    return (x >> 1) ^ (x[0] ? 32'hA300_0000 : 32'h0);
  endfunction

  task automatic sweep(input logic [31:0] den, input logic [31:0] ien, input int steps,
                       inout logic [31:0] seed);
    logic [31:0] d, e, u;
    wr(A_DET, den);
    wr(A_IEN, ien);
    for (int s = 0; s < steps; s++) begin
      u = pins;
      seed = lfsr(seed);
      wr(A_STAT | CLRO, 32'hFFFF_FFFF);
      pins = seed;
      repeat (4) @(posedge clk);
      #1;
      e = exp_stat(u, seed, den);
      rd(A_STAT, d);
      chk(d == e, "R6 R7 trigger sweep status", d, e);
      chk(irq == |(e & ien), "R8 irq from enabled status", {31'b0, irq}, {31'b0, |(e & ien)});
    end
  endtask

  initial begin
    logic [31:0] d, seed;
    seed = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(pin_out == 0 && pin_oe == 0, "R1 pin outputs at reset", pin_out | pin_oe, 0);
    chk(irq == 1'b0, "R1 irq at reset", {31'b0, irq}, 0);
    chk(rdata == 0, "R1 rdata at reset", rdata, 0);
    for (int r = 0; r < 8; r++) begin
      rd(8'(r * 16), d);
      chk(d == 0, "R1 register reset value", d, 0);
    end

    // R2 / R4 word, set and clear aliases
    wr(A_OUT, 32'h1234_5678);
    wr(A_OUT | SETO, 32'h8000_0001);
    rd(A_OUT, d);
    chk(d == 32'h9234_5679, "R2 set alias on output data", d, 32'h9234_5679);
    wr(A_OUT | CLRO, 32'h1200_0008);
    rd(A_OUT, d);
    chk(d == 32'h8034_5671, "R2 clear alias on output data", d, 32'h8034_5671);
    chk(pin_out == 32'h8034_5671, "R4 pin_o follows output data", pin_out, 32'h8034_5671);
    wr(A_OE, 32'h0F0F_0000);
    wr(A_OE | SETO, 32'h0000_00F0);
    wr(A_OE | CLRO, 32'h0100_0000);
    chk(pin_oe == 32'h0E0F_00F0, "R4 pin_oe_o follows enables", pin_oe, 32'h0E0F_00F0);
    wr(8'h80 | A_OUT, 32'hFFFF_FFFF);
    chk(pin_out == 32'h8034_5671, "R2 address bit 7 set ignored", pin_out, 32'h8034_5671);

    // R3 status only clears via clear alias; input data read-only
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_STAT | SETO, 32'hFFFF_FFFF);
    rd(A_STAT, d);
    chk(d == 0, "R3 word and set writes to status ignored", d, 0);
    wr(A_IN, 32'hFFFF_FFFF);
    rd(A_IN, d);
    chk(d == 0, "R3 input data not writable", d, 0);

    // R5 synchronizer depth
    @(negedge clk);
    pins = 32'h5A5A_0F0F;
    rd(A_IN, d);
    chk(d == 0, "R5 input one cycle after change is old", d, 0);
    rd(A_IN, d);
    chk(d == 32'h5A5A_0F0F, "R5 input after two stages", d, 32'h5A5A_0F0F);

    // configure trigger codes: all four per group of four pins
    wr(A_LVL, LVL_CFG);
    wr(A_POL, POL_CFG);

    // R9 low level on pin 1 re-asserts after clear
    @(negedge clk); pins = 32'h0;
    repeat (3) @(posedge clk);
    wr(A_DET, 32'h0000_0002);
    wr(A_STAT | CLRO, 32'hFFFF_FFFF);
    rd(A_STAT, d);
    chk(d == 32'h2, "R9 level re-sets after clear", d, 32'h2);
    @(negedge clk); pins = 32'h2;
    repeat (3) @(posedge clk);
    wr(A_STAT | CLRO, 32'h2);
    rd(A_STAT, d);
    chk(d == 0, "R9 level gone, clear sticks", d, 0);

    // R10 rising edge on pin 2 lands in the same cycle as its clear
    wr(A_DET, 32'h0000_0004);
    @(negedge clk); pins = 32'h2;
    repeat (2) @(posedge clk);
    wr(A_STAT | CLRO, 32'h4);
    @(negedge clk); pins = 32'h6;
    @(posedge clk); @(posedge clk);
    wr(A_STAT | CLRO, 32'h4);
    rd(A_STAT, d);
    chk(d == 32'h4, "R10 event wins over clear", d, 32'h4);

    // R8 interrupt enable gates only the line
    wr(A_IEN, 32'h0);
    #1;
    chk(irq == 1'b0, "R8 irq low with enable off", {31'b0, irq}, 0);
    rd(A_STAT, d);
    chk(d == 32'h4, "R8 enable does not touch status", d, 32'h4);
    wr(A_IEN, 32'h4);
    #1;
    chk(irq == 1'b1, "R8 irq high when enabled", {31'b0, irq}, 1);

    // R6 R7 R8 sweeps
    sweep(32'hFFFF_FFFF, 32'hFFFF_FFFF, 120, seed);
    sweep(32'h0F0F_F0F0, 32'h00FF_00FF, 120, seed);
    sweep(32'h0000_0000, 32'hFFFF_FFFF, 20, seed);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule